// File: doc/BRIEF.md
# Time-Multiplexed Regression Term Engine

This block turns six finished running sums into the numerator and denominator terms of a least-squares line fit. The sums are: the sample count n, sum of x, sum of y, sum of x squared, sum of y squared and sum of x·y. From these it produces five wide signed terms. The slope numerator is F = n·Σxy − Σx·Σy. The intercept numerator is G = Σy·Σx² − Σx·Σxy. The shared variance term is J = n·Σx² − (Σx)², and the error denominator is K = n·J. The error numerator is H = J·Σy² + (2·Σx·Σxy − Σy·Σx²)·Σy − n·(Σxy)². A divider or a threshold comparator further down the chain uses these terms. The accumulator that forms the sums is upstream and is not part of this block.

The block has one multiplier, one adder/subtractor and twelve working slots. A microcode sequencer drives them over a fixed script of eighteen steps. The first six steps form the pairwise products. The later steps overwrite the slots in slot order, and each slot is overwritten only after its old value has been read for the last time. The doubling of Σx·Σxy is a wired shift on the adder's first operand. The schedule does not depend on n, so the latency is constant. The accumulator may therefore keep collecting the next regression while this block finishes the current one, as long as each regression has enough samples.

Top module: `lr_tm_core`

## Requirements
- R1: After reset, busy, done and overrun are low and all five term outputs read zero.
- R2: A sums_valid pulse while idle captures the six sums, and busy is high from the next cycle until done.
- R3: done is a one-cycle pulse. It is visible in the cycle after the 19th rising edge that follows the accepting edge, whatever the sum values and n.
- R4: slope_num equals n·Σxy − Σx·Σy.
- R5: icpt_num equals Σy·Σx² − Σx·Σxy.
- R6: var_den equals n·Σx² − (Σx)², and err_den equals n times that value.
- R7: err_num equals var_den·Σy² + (2·Σx·Σxy − Σy·Σx²)·Σy − n·(Σxy)².
- R8: Inputs are IN_W-bit two's complement and outputs are RW-bit two's complement. Negative and full-scale sums give exact results within RW bits.
- R9: A sums_valid seen while busy is ignored: the running computation and its results are unchanged, and overrun pulses high for one cycle in the next cycle.
- R10: The term outputs hold their values from the done cycle until the next accepted sums_valid. A sums_valid in the done cycle itself is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| sums_valid | input | 1 | The six sums are valid this cycle |
| sum_x | input | IN_W | Σx |
| sum_y | input | IN_W | Σy |
| sum_xx | input | IN_W | Σx² |
| sum_yy | input | IN_W | Σy² |
| sum_xy | input | IN_W | Σxy |
| sum_cnt | input | IN_W | n, the sample count |
| busy | output | 1 | Script running |
| done | output | 1 | One-cycle pulse, terms are valid |
| overrun | output | 1 | One-cycle pulse after a sums_valid that was ignored |
| slope_num | output | RW | F |
| icpt_num | output | RW | G |
| err_num | output | RW | H |
| var_den | output | RW | J (also I) |
| err_den | output | RW | K |

## Verification
The bench records the cycle at which each sum set is accepted and expects done exactly 19 edges later. It then compares all five terms against values computed from the formulas in that same cycle. busy is sampled one cycle after acceptance. overrun is sampled one cycle after a sums_valid given mid-run. For that run, the late results and the on-time done confirm that the extra pulse was ignored. After the last run, the outputs are sampled for several idle cycles while the sum inputs change, to confirm that they hold.

// File: rtl/lr_tm_pkg.sv
package lr_tm_pkg;

   localparam int NREG   = 12;
   localparam int RIDX_W = 4;
   localparam int NLOAD  = 6;
   localparam int NSTEP  = 18;

   // slots where the finished terms end up
   localparam int SLOT_J = 0;
   localparam int SLOT_K = 1;
   localparam int SLOT_F = 7;
   localparam int SLOT_G = 8;
   localparam int SLOT_H = 9;

   typedef enum logic [1:0] {OP_NOP, OP_MUL, OP_ADD, OP_SUB} op_e;

   typedef struct packed {
      op_e               op;
      logic [RIDX_W-1:0] sa;
      logic [RIDX_W-1:0] sb;
      logic              dbl;
      logic [RIDX_W-1:0] dst;
   } uinst_t;

   function automatic uinst_t mk(input op_e o, input int a, input int b,
                                 input logic d, input int w);
      uinst_t u;
      u.op  = o;
      u.sa  = RIDX_W'(a);
      u.sb  = RIDX_W'(b);
      u.dbl = d;
      u.dst = RIDX_W'(w);
      return u;
   endfunction

   // load slots: 0 sxx, 1 n, 2 syy, 3 sxy, 4 sx, 5 sy
   function automatic uinst_t ucode(input int k);
      case (k)
         0:  return mk(OP_MUL, 1, 0, 1'b0, 6);    // n*sxx
         1:  return mk(OP_MUL, 4, 4, 1'b0, 7);    // sx^2
         2:  return mk(OP_MUL, 4, 5, 1'b0, 8);    // sx*sy
         3:  return mk(OP_MUL, 5, 0, 1'b0, 9);    // sy*sxx
         4:  return mk(OP_MUL, 4, 3, 1'b0, 10);   // sx*sxy
         5:  return mk(OP_MUL, 1, 3, 1'b0, 11);   // n*sxy
         6:  return mk(OP_SUB, 6, 7, 1'b0, 0);    // J
         7:  return mk(OP_NOP, 0, 0, 1'b0, 0);    // wait for J
         8:  return mk(OP_MUL, 1, 0, 1'b0, 1);    // K
         9:  return mk(OP_MUL, 2, 0, 1'b0, 2);    // syy*J
         10: return mk(OP_MUL, 11, 3, 1'b0, 3);   // n*sxy^2
         11: return mk(OP_SUB, 10, 9, 1'b1, 4);   // 2*sx*sxy - sy*sxx
         12: return mk(OP_NOP, 0, 0, 1'b0, 0);    // wait for slot 4
         13: return mk(OP_MUL, 5, 4, 1'b0, 5);    // sy*(...)
         14: return mk(OP_SUB, 2, 3, 1'b0, 6);    // syy*J - n*sxy^2
         15: return mk(OP_SUB, 11, 8, 1'b0, 7);   // F
         16: return mk(OP_SUB, 9, 10, 1'b0, 8);   // G
         17: return mk(OP_ADD, 6, 5, 1'b0, 9);    // H
         default: return mk(OP_NOP, 0, 0, 1'b0, 0);
      endcase
   endfunction

endpackage

// File: rtl/lr_tm_seq.sv
module lr_tm_seq
   import lr_tm_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   sums_valid,
   output logic   busy,
   output logic   done,
   output logic   overrun,
   output logic   load,
   output logic   issue,
   output uinst_t uinst
);

   localparam int CNT_W = $clog2(NSTEP + 1);

   logic [CNT_W-1:0] cnt;
   logic             in_script;

   assign load      = sums_valid && !busy;
   assign in_script = busy && (cnt < CNT_W'(NSTEP));
   assign uinst     = in_script ? ucode(int'(cnt)) : mk(OP_NOP, 0, 0, 1'b0, 0);
   assign issue     = in_script && (uinst.op != OP_NOP);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         done    <= 1'b0;
         overrun <= 1'b0;
         cnt     <= '0;
      end else begin
         done    <= 1'b0;
         overrun <= sums_valid && busy;
         if (load) begin
            busy <= 1'b1;
            cnt  <= '0;
         end else if (busy) begin
            if (cnt == CNT_W'(NSTEP)) begin
               busy <= 1'b0;
               done <= 1'b1;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
      end
   end

   // R9
   overrun_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sums_valid && busy) |=> overrun);

   // R3
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R3
   done_ends_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ($past(busy) && !busy));

endmodule

// File: rtl/lr_tm_rf.sv
module lr_tm_rf
   import lr_tm_pkg::*;
#(
   parameter int IN_W = 16,
   parameter int RW   = 52
)(
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   load,
   input  logic [NLOAD*IN_W-1:0]  load_data,
   input  logic                   wen,
   input  logic [RIDX_W-1:0]      wdst,
   input  logic signed [RW-1:0]   wdata,
   input  logic [RIDX_W-1:0]      rsa,
   input  logic [RIDX_W-1:0]      rsb,
   output logic signed [RW-1:0]   rda,
   output logic signed [RW-1:0]   rdb,
   output logic signed [RW-1:0]   t_f,
   output logic signed [RW-1:0]   t_g,
   output logic signed [RW-1:0]   t_h,
   output logic signed [RW-1:0]   t_j,
   output logic signed [RW-1:0]   t_k
);

   logic signed [RW-1:0] regs [NREG];

   for (genvar s = 0; s < NREG; s++) begin : g_slot
      if (s < NLOAD) begin : g_loadable
         always_ff @(posedge clk) begin
            if (!rst_n)
               regs[s] <= '0;
            else if (load)
               regs[s] <= RW'($signed(load_data[s*IN_W +: IN_W]));
            else if (wen && wdst == RIDX_W'(s))
               regs[s] <= wdata;
         end
      end else begin : g_work
         always_ff @(posedge clk) begin
            if (!rst_n)
               regs[s] <= '0;
            else if (wen && wdst == RIDX_W'(s))
               regs[s] <= wdata;
         end
      end
   end

   assign rda = regs[rsa];
   assign rdb = regs[rsb];
   assign t_f = regs[SLOT_F];
   assign t_g = regs[SLOT_G];
   assign t_h = regs[SLOT_H];
   assign t_j = regs[SLOT_J];
   assign t_k = regs[SLOT_K];

   // R2
   load_wb_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(load && wen));

endmodule

// File: rtl/lr_tm_alu.sv
module lr_tm_alu
   import lr_tm_pkg::*;
#(
   parameter int RW = 52
)(
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  issue,
   input  op_e                   op,
   input  logic                  dbl,
   input  logic [RIDX_W-1:0]     dst,
   input  logic signed [RW-1:0]  opa,
   input  logic signed [RW-1:0]  opb,
   output logic                  wen_q,
   output logic [RIDX_W-1:0]     dst_q,
   output logic signed [RW-1:0]  res_q
);

   logic signed [RW-1:0] a_eff;
   logic signed [RW-1:0] b_add;
   logic signed [RW-1:0] sum;
   logic signed [RW-1:0] prod;
   logic signed [RW-1:0] result;
   logic                 is_sub;

   // doubling is a wired shift
   assign a_eff  = dbl ? {opa[RW-2:0], 1'b0} : opa;
   assign is_sub = (op == OP_SUB);
   assign b_add  = is_sub ? ~opb : opb;
   assign sum    = a_eff + b_add + {{(RW-1){1'b0}}, is_sub};
   assign prod   = a_eff * opb;
   assign result = (op == OP_MUL) ? prod : sum;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wen_q <= 1'b0;
         dst_q <= '0;
         res_q <= '0;
      end else begin
         wen_q <= issue;
         if (issue) begin
            dst_q <= dst;
            res_q <= result;
         end
      end
   end

endmodule

// File: rtl/lr_tm_core.sv
module lr_tm_core
   import lr_tm_pkg::*;
#(
   parameter int IN_W = 16,
   parameter int RW   = 3*IN_W + 4
)(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 sums_valid,
   input  logic [IN_W-1:0]      sum_x,
   input  logic [IN_W-1:0]      sum_y,
   input  logic [IN_W-1:0]      sum_xx,
   input  logic [IN_W-1:0]      sum_yy,
   input  logic [IN_W-1:0]      sum_xy,
   input  logic [IN_W-1:0]      sum_cnt,
   output logic                 busy,
   output logic                 done,
   output logic                 overrun,
   output logic [RW-1:0]        slope_num,
   output logic [RW-1:0]        icpt_num,
   output logic [RW-1:0]        err_num,
   output logic [RW-1:0]        var_den,
   output logic [RW-1:0]        err_den
);

   if (IN_W < 2) begin : g_bad_in
      $error("lr_tm_core: IN_W must be at least 2");
   end
   if (RW < 3*IN_W + 4) begin : g_bad_rw
      $error("lr_tm_core: RW too narrow for the error numerator");
   end

   logic                 load, issue, wen_q;
   uinst_t               uinst;
   logic [RIDX_W-1:0]    dst_q;
   logic signed [RW-1:0] rda, rdb, res_q;
   logic signed [RW-1:0] t_f, t_g, t_h, t_j, t_k;
   logic [NLOAD*IN_W-1:0] load_data;

   // slot order matches the microcode: sxx, n, syy, sxy, sx, sy
   assign load_data = {sum_y, sum_x, sum_xy, sum_yy, sum_cnt, sum_xx};

   lr_tm_seq u_seq (
      .clk(clk), .rst_n(rst_n), .sums_valid(sums_valid),
      .busy(busy), .done(done), .overrun(overrun),
      .load(load), .issue(issue), .uinst(uinst)
   );

   lr_tm_rf #(.IN_W(IN_W), .RW(RW)) u_rf (
      .clk(clk), .rst_n(rst_n), .load(load), .load_data(load_data),
      .wen(wen_q), .wdst(dst_q), .wdata(res_q),
      .rsa(uinst.sa), .rsb(uinst.sb), .rda(rda), .rdb(rdb),
      .t_f(t_f), .t_g(t_g), .t_h(t_h), .t_j(t_j), .t_k(t_k)
   );

   lr_tm_alu #(.RW(RW)) u_alu (
      .clk(clk), .rst_n(rst_n), .issue(issue), .op(uinst.op),
      .dbl(uinst.dbl), .dst(uinst.dst), .opa(rda), .opb(rdb),
      .wen_q(wen_q), .dst_q(dst_q), .res_q(res_q)
   );

   assign slope_num = t_f;
   assign icpt_num  = t_g;
   assign err_num   = t_h;
   assign var_den   = t_j;
   assign err_den   = t_k;

   // R10
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !sums_valid) |=> ($stable(slope_num) && $stable(icpt_num) &&
                                  $stable(err_num) && $stable(var_den) &&
                                  $stable(err_den)));

endmodule

// File: tb/lr_tm_core_tb_top.sv
module lr_tm_core_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int IN_W = 16;
   localparam int RW   = 3*IN_W + 4;
   localparam int LAT  = 19;

   typedef struct {
      longint f, g, h, j, k;
      longint due;
   } exp_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sums_valid = 1'b0;
   logic [IN_W-1:0] sx = '0, sy = '0, sxx = '0, syy = '0, sxy = '0, sn = '0;
   logic busy, done, overrun;
   logic [RW-1:0] slope_num, icpt_num, err_num, var_den, err_den;

   int     tests = 0;
   int     fails = 0;
   longint cyc = 0;
   exp_t   sb[$];
   exp_t   last_exp;
   logic   done_prev = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   lr_tm_core #(.IN_W(IN_W), .RW(RW)) dut_i (
      .clk(clk), .rst_n(rst_n), .sums_valid(sums_valid),
      .sum_x(sx), .sum_y(sy), .sum_xx(sxx), .sum_yy(syy), .sum_xy(sxy), .sum_cnt(sn),
      .busy(busy), .done(done), .overrun(overrun),
      .slope_num(slope_num), .icpt_num(icpt_num), .err_num(err_num),
      .var_den(var_den), .err_den(err_den)
   );

   task automatic chk(input string req, input longint act, input longint exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic longint sx64(input logic [RW-1:0] v);
      return longint'($signed(v));
   endfunction

   // called at a negedge; holds sums_valid for one cycle
   task automatic drive_set(input longint a, input longint b, input longint c,
                            input longint d, input longint e, input longint n);
      exp_t x;
      longint jv;
      jv    = n*c - a*a;
      x.f   = n*e - a*b;
      x.g   = b*c - a*e;
      x.j   = jv;
      x.k   = n*jv;
      x.h   = jv*d + (2*a*e - b*c)*b - n*e*e;
      x.due = cyc + 1 + LAT;
      sx = IN_W'(a); sy = IN_W'(b); sxx = IN_W'(c);
      syy = IN_W'(d); sxy = IN_W'(e); sn = IN_W'(n);
      sums_valid = 1'b1;
      sb.push_back(x);
      @(negedge clk);
      sums_valid = 1'b0;
      chk("R2 busy after accept", longint'(busy), 1);
   endtask

   task automatic wait_done();
      do @(negedge clk); while (!done);
   endtask

   // monitor: pops the scoreboard on each done
   always @(negedge clk) begin
      if (rst_n) begin
         if (done && done_prev) chk("R3 done width", 2, 1);
         if (done) begin
            if (sb.size() == 0) begin
               chk("R3 unexpected done", 1, 0);
            end else begin
               exp_t x;
               x = sb.pop_front();
               last_exp = x;
               chk("R3 done cycle", cyc, x.due);
               chk("R4 slope_num", sx64(slope_num), x.f);
               chk("R5 icpt_num",  sx64(icpt_num),  x.g);
               chk("R6 var_den",   sx64(var_den),   x.j);
               chk("R6 err_den",   sx64(err_den),   x.k);
               chk("R7 err_num",   sx64(err_num),   x.h);
            end
         end
         done_prev <= done;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 busy", longint'(busy), 0);
      chk("R1 done", longint'(done), 0);
      chk("R1 overrun", longint'(overrun), 0);
      chk("R1 slope_num", sx64(slope_num), 0);
      chk("R1 err_den", sx64(err_den), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // plain positive set
      drive_set(10, 25, 30, 130, 70, 5);
      wait_done();
      @(negedge clk);

      // R8 negative sums
      drive_set(-12, 40, 90, 500, -75, 7);
      wait_done();
      @(negedge clk);

      // single sample: J and K become zero
      drive_set(3, -4, 9, 16, -12, 1);
      wait_done();
      @(negedge clk);

      // R8 full-scale values
      drive_set(-32768, 32767, 32767, 32767, -32768, 32767);
      wait_done();
      @(negedge clk);

      // R9 extra sums_valid while busy
      drive_set(7, 3, 20, 11, 9, 4);
      repeat (5) @(negedge clk);
      sx = 16'h1234; sy = 16'h0F0F; sn = 16'h0002;
      sums_valid = 1'b1;
      @(negedge clk);
      sums_valid = 1'b0;
      chk("R9 overrun pulse", longint'(overrun), 1);
      @(negedge clk);
      chk("R9 overrun clears", longint'(overrun), 0);
      wait_done();

      // R10 back-to-back: new set in the done cycle
      drive_set(-5, -6, 15, 20, 8, 3);
      wait_done();
      drive_set(100, -200, 4000, 9000, -1500, 50);
      wait_done();

      // R10 hold while idle with moving inputs
      for (int i = 0; i < 8; i++) begin
         @(negedge clk);
         sx = IN_W'(i * 37); sy = IN_W'(i * 11); sn = IN_W'(i + 2);
      end
      chk("R10 hold slope_num", sx64(slope_num), last_exp.f);
      chk("R10 hold err_num",   sx64(err_num),   last_exp.h);
      chk("R10 hold err_den",   sx64(err_den),   last_exp.k);
      chk("R10 no done idle",   longint'(done),  0);
      chk("R10 scoreboard empty", longint'(sb.size()), 0);

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule